// File: doc/BRIEF.md
# Halt-State Power Controller

This block sits beside a small processor core. It decides when the core's clock runs and when it is held off. It watches the stream of executed opcodes. When a halt opcode arrives directly after a no-operation opcode, meaning the pipeline has already been flushed, the controller parks the core: the core clock enable drops, and the free-running source clock keeps reaching the timers and the interrupt logic. A matching stop opcode enters a deeper state in which the peripheral clock enable drops as well.

The controller wakes the core in one of two ways, depending on the source of the wake:
- An interrupt ends halt with a one-cycle resume pulse. The core then services the interrupt and carries on after the halt opcode.
- A reset request or a watchdog timeout ends halt with a one-cycle restart pulse. The restart vector 0x000C is presented alongside the pulse.

Two select bits scale the core clock by 1, 2, 4 or 8. Software may rewrite them at any time. A new setting is only adopted at the boundary of a divided period, so no partial period is ever produced. The core clock is gated through a latch that is transparent while the source clock is low, so the gated clock carries no glitches.

States and transitions:
- RUN → HALT on an accepted halt opcode.
- RUN → STOP on an accepted stop opcode.
- HALT → RUN on an interrupt (resume) or on a reset request or watchdog timeout (restart).
- STOP → RUN on a reset request only (restart).

Top module: `pwr_halt_ctrl`

## Requirements
- R1: After the asynchronous reset `rst_n` is released, the state is RUN (`pstate` = 2'b00), the scaling is divide-by-1, `halt_err`, `wake_resume` and `restart_req` are low, and `cpu_clk_en` is high on every cycle.
- R2: A valid opcode 0x7F, whose previous valid opcode accepted in RUN was 0xFF, moves the state to HALT (`pstate` = 2'b01) at that clock edge. Cycles in which `op_valid` is low do not break this pairing.
- R3: A valid opcode 0x7F not directly preceded by a valid 0xFF leaves the state in RUN. It raises `halt_err` for exactly one cycle after that edge.
- R4: Outside RUN, `cpu_clk_en` stays low and opcodes are ignored. An 0xFF seen while halted does not count as a preceding no-operation after wake.
- R5: In HALT, `irq` high at a clock edge returns the state to RUN at that edge. `wake_resume` is high for exactly the following cycle.
- R6: In HALT, `ext_rst_req` or `wdt_timeout` high at a clock edge returns the state to RUN at that edge. `restart_req` is high for exactly the following cycle, with `restart_vec` = 0x000C.
- R7: When a restart source and `irq` are both high at the same edge in HALT, only `restart_req` pulses; `wake_resume` stays low.
- R8: A valid opcode 0x6F directly preceded by a valid 0xFF moves the state to STOP (`pstate` = 2'b10). In STOP, `irq` and `wdt_timeout` are ignored, and only `ext_rst_req` returns to RUN, with a `restart_req` pulse.
- R9: `clk_div_sel` encodes 00 = divide-by-1, 01 = divide-by-2, 10 = divide-by-4, 11 = divide-by-8. In RUN, `cpu_clk_en` is high for one source cycle out of each divided period.
- R10: A new `clk_div_sel` value is sampled only on a cycle in which the divided period ends. The current period always completes at its old length.
- R11: `periph_clk_en` is high in RUN and HALT and low in STOP. `periph_clk` and `cpu_clk` are the source clock gated by the respective enables.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running source clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| op_valid | input | 1 | An opcode is executed this cycle |
| op_code | input | 8 | Executed opcode |
| irq | input | 1 | Any enabled interrupt request |
| ext_rst_req | input | 1 | Synchronous external reset request |
| wdt_timeout | input | 1 | Watchdog timeout |
| clk_div_sel | input | 2 | Core clock scaling select |
| cpu_clk_en | output | 1 | Core clock enable for this cycle |
| cpu_clk | output | 1 | Gated, scaled core clock |
| periph_clk_en | output | 1 | Peripheral clock enable |
| periph_clk | output | 1 | Gated peripheral clock |
| pstate | output | 2 | Current state: 00 run, 01 halt, 10 stop |
| halt_err | output | 1 | Halt opcode arrived without a flushed pipeline |
| wake_resume | output | 1 | Interrupt wake pulse |
| restart_req | output | 1 | Reset/watchdog wake pulse |
| restart_vec | output | 16 | Restart address, 0x000C |

## Verification
Two things can land on the same edge while halted: an interrupt wake and a reset or watchdog wake. The bench raises `irq` together with `wdt_timeout`, and in another case together with `ext_rst_req`. It judges that only the restart pulse appears, with the vector. A scaling change is also written in the middle of a divided period, just before a halt entry. A behavioural model decides on which cycles the core enable must pulse, and each cycle is compared against it.

// File: rtl/halt_pkg.sv
package halt_pkg;
    typedef enum logic [1:0] {
        PS_RUN  = 2'b00,
        PS_HALT = 2'b01,
        PS_STOP = 2'b10
    } pstate_t;
endpackage

// File: rtl/halt_op_decode.sv
module halt_op_decode #(
    parameter int          OPW     = 8,
    parameter logic [7:0]  NOP_OP  = 8'hFF,
    parameter logic [7:0]  HALT_OP = 8'h7F,
    parameter logic [7:0]  STOP_OP = 8'h6F
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           accept,
    input  logic           op_valid,
    input  logic [OPW-1:0] op_code,
    output logic           halt_go,
    output logic           stop_go,
    output logic           halt_bad
);
    logic flushed_q;
    logic take;

    assign take     = accept && op_valid;
    assign halt_go  = take && (op_code == OPW'(HALT_OP)) && flushed_q;
    assign stop_go  = take && (op_code == OPW'(STOP_OP)) && flushed_q;
    assign halt_bad = take && (op_code == OPW'(HALT_OP)) && !flushed_q;

    // remembers whether the last accepted opcode was the pipeline flush
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            flushed_q <= 1'b0;
        else if (take)
            flushed_q <= (op_code == OPW'(NOP_OP));
    end

    // R2 / R3: entry and error never coincide
    a_r3_go_or_bad: assert property (@(posedge clk) disable iff (!rst_n)
        !(halt_go && halt_bad));
endmodule

// File: rtl/clk_scaler.sv
module clk_scaler #(
    parameter int SEL_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);
    localparam int MAXSH = (1 << SEL_W) - 1;
    localparam int CNT_W = (MAXSH > 0) ? MAXSH : 1;

    logic [CNT_W-1:0] cnt_q;

    assign tick = (cnt_q == '0);

    // new select is taken only when a divided period ends
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (tick)
            cnt_q <= (CNT_W'(1) << sel) - CNT_W'(1);
        else
            cnt_q <= cnt_q - CNT_W'(1);
    end

    // R10: counter only moves down between period boundaries
    a_r10_count_down: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> cnt_q == $past(cnt_q) - CNT_W'(1));
endmodule

// File: rtl/clk_gate_cell.sv
module clk_gate_cell (
    input  logic clk,
    input  logic en,
    output logic gclk
);
    logic en_lat;

    // transparent in the low phase so the high phase is never cut short
    always_latch begin
        if (!clk)
            en_lat = en;
    end

    assign gclk = clk & en_lat;
endmodule

// File: rtl/pwr_halt_ctrl.sv
module pwr_halt_ctrl #(
    parameter int          OPW         = 8,
    parameter int          SEL_W       = 2,
    parameter int          VEC_W       = 16,
    parameter logic [15:0] RESTART_VEC = 16'h000C
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             op_valid,
    input  logic [OPW-1:0]   op_code,
    input  logic             irq,
    input  logic             ext_rst_req,
    input  logic             wdt_timeout,
    input  logic [SEL_W-1:0] clk_div_sel,
    output logic             cpu_clk_en,
    output logic             cpu_clk,
    output logic             periph_clk_en,
    output logic             periph_clk,
    output logic [1:0]       pstate,
    output logic             halt_err,
    output logic             wake_resume,
    output logic             restart_req,
    output logic [VEC_W-1:0] restart_vec
);
    import halt_pkg::*;

    pstate_t state_q, state_d;
    logic    halt_go, stop_go, halt_bad, tick;
    logic    hard_wake;
    logic    err_q, resume_q, restart_q;

    halt_op_decode #(.OPW(OPW)) u_dec (
        .clk      (clk),
        .rst_n    (rst_n),
        .accept   (state_q == PS_RUN),
        .op_valid (op_valid),
        .op_code  (op_code),
        .halt_go  (halt_go),
        .stop_go  (stop_go),
        .halt_bad (halt_bad)
    );

    clk_scaler #(.SEL_W(SEL_W)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .sel   (clk_div_sel),
        .tick  (tick)
    );

    assign hard_wake = ext_rst_req || wdt_timeout;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PS_RUN: begin
                if (halt_go)      state_d = PS_HALT;
                else if (stop_go) state_d = PS_STOP;
            end
            PS_HALT: begin
                if (hard_wake || irq) state_d = PS_RUN;
            end
            PS_STOP: begin
                if (ext_rst_req) state_d = PS_RUN;
            end
            default: state_d = PS_RUN;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PS_RUN;
        else        state_q <= state_d;
    end

    // registered event outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            err_q     <= 1'b0;
            resume_q  <= 1'b0;
            restart_q <= 1'b0;
        end else begin
            err_q     <= halt_bad;
            resume_q  <= (state_q == PS_HALT) && irq && !hard_wake;
            restart_q <= ((state_q == PS_HALT) && hard_wake) ||
                         ((state_q == PS_STOP) && ext_rst_req);
        end
    end

    assign pstate        = state_q;
    assign halt_err      = err_q;
    assign wake_resume   = resume_q;
    assign restart_req   = restart_q;
    assign restart_vec   = VEC_W'(RESTART_VEC);
    assign cpu_clk_en    = (state_q == PS_RUN) && tick;
    assign periph_clk_en = (state_q != PS_STOP);

    clk_gate_cell u_cpu_gate (.clk(clk), .en(cpu_clk_en),    .gclk(cpu_clk));
    clk_gate_cell u_per_gate (.clk(clk), .en(periph_clk_en), .gclk(periph_clk));

    a_r4_no_cpu_clk_parked: assert property (@(posedge clk) disable iff (!rst_n)
        state_q != PS_RUN |-> !cpu_clk_en);
    a_r3_err_stays_run: assert property (@(posedge clk) disable iff (!rst_n)
        halt_err |-> state_q == PS_RUN);
    a_r5_resume_after_halt: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wake_resume) |-> state_q == PS_RUN);
    a_r7_single_wake_kind: assert property (@(posedge clk) disable iff (!rst_n)
        !(wake_resume && restart_req));
    a_r6_restart_lands_run: assert property (@(posedge clk) disable iff (!rst_n)
        restart_req |-> state_q == PS_RUN);
    a_r11_stop_periph_off: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == PS_STOP |-> !periph_clk_en);
    a_r8_stop_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PS_STOP && !ext_rst_req) |=> state_q == PS_STOP);
endmodule

// File: tb/tb_pwr_halt_ctrl.sv
module tb_pwr_halt_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       op_valid = 1'b0;
    logic [7:0] op_code = 8'h00;
    logic       irq = 1'b0, ext_rst_req = 1'b0, wdt_timeout = 1'b0;
    logic [1:0] clk_div_sel = 2'b00;
    logic       cpu_clk_en, cpu_clk, periph_clk_en, periph_clk;
    logic [1:0] pstate;
    logic       halt_err, wake_resume, restart_req;
    logic [15:0] restart_vec;

    int checks = 0, fails = 0;
    bit finished = 0;

    always #4 clk = ~clk;  // 125 MHz

    pwr_halt_ctrl dut (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
        .irq(irq), .ext_rst_req(ext_rst_req), .wdt_timeout(wdt_timeout),
        .clk_div_sel(clk_div_sel), .cpu_clk_en(cpu_clk_en), .cpu_clk(cpu_clk),
        .periph_clk_en(periph_clk_en), .periph_clk(periph_clk), .pstate(pstate),
        .halt_err(halt_err), .wake_resume(wake_resume), .restart_req(restart_req),
        .restart_vec(restart_vec)
    );

    // behavioural reference model
    int m_state = 0;      // 0 run, 1 halt, 2 stop
    bit m_flushed = 0, m_err = 0, m_resume = 0, m_restart = 0;
    int m_left = 0;       // cycles until the current divided period ends

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_state = 0; m_flushed = 0; m_err = 0; m_resume = 0; m_restart = 0; m_left = 0;
        end else begin
            int ns; bit hard;
            ns = m_state; hard = ext_rst_req || wdt_timeout;
            m_err = 0; m_resume = 0; m_restart = 0;
            if (m_state == 0) begin
                if (op_valid) begin
                    if (op_code == 8'h7F && m_flushed) ns = 1;
                    else if (op_code == 8'h6F && m_flushed) ns = 2;
                    else if (op_code == 8'h7F) m_err = 1;
                    m_flushed = (op_code == 8'hFF);
                end
            end else if (m_state == 1) begin
                if (hard) begin ns = 0; m_restart = 1; end
                else if (irq) begin ns = 0; m_resume = 1; end
            end else begin
                if (ext_rst_req) begin ns = 0; m_restart = 1; end
            end
            m_state = ns;
            if (m_left == 0) m_left = (1 << clk_div_sel) - 1;
            else m_left = m_left - 1;
        end
    end

    task automatic chk(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // cycle compare, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            chk("R2", "pstate", pstate, m_state);
            chk("R9", "cpu_clk_en", cpu_clk_en, (m_state == 0 && m_left == 0));
            chk("R3", "halt_err", halt_err, m_err);
            chk("R5", "wake_resume", wake_resume, m_resume);
            chk("R6", "restart_req", restart_req, m_restart);
            if (restart_req) chk("R6", "restart_vec", restart_vec, 16'h000C);
            chk("R11", "periph_clk_en", periph_clk_en, (m_state != 2));
        end
    end

    task automatic cyc(bit v, logic [7:0] op, bit i, bit e, bit w);
        @(negedge clk);
        op_valid = v; op_code = op; irq = i; ext_rst_req = e; wdt_timeout = w;
    endtask
    task automatic idle(int n);
        for (int k = 0; k < n; k++) cyc(0, 8'h00, 0, 0, 0);
    endtask
    task automatic op(logic [7:0] c);
        cyc(1, c, 0, 0, 0);
    endtask

    task automatic summary;
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk("R1", "pstate after reset", pstate, 0);
        chk("R1", "cpu_clk_en after reset", cpu_clk_en, 1);
        chk("R1", "restart_req after reset", restart_req, 0);
        idle(6);
        // R2: flush then halt
        op(8'hFF); op(8'h7F); idle(1);
        chk("R2", "entered halt", pstate, 1);
        // R4: opcodes ignored while halted
        op(8'hFF); op(8'h6F); idle(3);
        chk("R4", "still halted", pstate, 1);
        // R5: interrupt wake
        cyc(0, 8'h00, 1, 0, 0); idle(1);
        chk("R5", "resumed", pstate, 0);
        idle(2);
        // R3 / R4: halt without flush (0xFF seen in halt does not count)
        op(8'h7F); idle(1);
        chk("R3", "stays run", pstate, 0);
        op(8'h00); op(8'h7F); idle(2);
        // R2: gap cycles between flush and halt
        op(8'hFF); idle(2); op(8'h7F); idle(3);
        // R6: watchdog wake
        cyc(0, 8'h00, 0, 0, 1); idle(3);
        op(8'hFF); op(8'h7F); idle(2);
        cyc(0, 8'h00, 0, 1, 0); idle(3);
        // R7: interrupt with watchdog and with reset in the same cycle
        op(8'hFF); op(8'h7F); idle(2);
        cyc(0, 8'h00, 1, 0, 1); idle(1);
        chk("R7", "no resume on joint wake", wake_resume, 0);
        idle(2);
        op(8'hFF); op(8'h7F); idle(2);
        cyc(0, 8'h00, 1, 1, 0); idle(3);
        // R9 / R10: scaling, changed mid-period
        clk_div_sel = 2'b01; idle(12);
        clk_div_sel = 2'b11; idle(3);
        clk_div_sel = 2'b10; idle(20);
        clk_div_sel = 2'b11; idle(21);
        op(8'hFF); op(8'h7F); idle(9);
        cyc(0, 8'h00, 1, 0, 0); idle(20);
        clk_div_sel = 2'b00; idle(10);
        // R8: stop state
        op(8'hFF); op(8'h6F); idle(1);
        chk("R8", "entered stop", pstate, 2);
        cyc(0, 8'h00, 1, 0, 1); idle(3);
        chk("R8", "irq and watchdog ignored in stop", pstate, 2);
        chk("R11", "periph off in stop", periph_clk_en, 0);
        cyc(0, 8'h00, 0, 1, 0); idle(4);
        chk("R8", "reset leaves stop", pstate, 0);
        idle(4);
        summary();
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++; fails++;
            $display("FAIL watchdog expired actual=1 expected=0");
            summary();
        end
    end
endmodule